// File: doc/BRIEF.md
# Framed Serial Word Receiver with Chain Output

This block is the receiving end of a converter's serial control port. A host lowers an active-low frame strobe, toggles a serial clock and presents one data bit per clock. On each falling serial clock edge inside the frame, the block shifts the bit into a 16-bit shift register, most significant bit first. When the strobe rises, the word is copied to a holding register and a one-cycle update strobe is raised, but only if at least 16 falling edges were seen in the frame. A frame that closes earlier leaves the holding register as it was.

The strobe, serial clock and data are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its value one cycle earlier. Several receivers can share one frame strobe and serial clock in a chain. Once a frame runs past 16 edges, each extra edge pushes the register's top bit out on the serial output, which can drive the next receiver's data input. When such a long frame closes, each receiver keeps the last 16 bits it received.

Top module: `serial_frame_rx`

## Requirements
- R1: A bit is taken into the shift register only on a falling serial clock edge while the frame strobe is low. Rising serial clock edges, and any clock activity while the strobe is high, shift nothing.
- R2: The word is received most significant bit first. On commit, `word_q` holds the last 16 bits received in the frame, with the earliest of them in bit 15.
- R3: `word_q` changes only in the cycle in which `upd_p` is high. At all other times it holds its value.
- R4: A frame whose strobe rises after fewer than 16 falling clock edges is discarded. This includes a frame with exactly 15 edges. No `upd_p` pulse is produced and `word_q` keeps its previous value.
- R5: `sdo` stays low during the first 16 falling edges of a frame. From the 17th edge onward, each edge drives out the bit received 16 edges earlier. `sdo` returns low when the frame opens and when it closes.
- R6: Each committed frame produces exactly one `upd_p` pulse, which is high for exactly one system clock cycle.
- R7: After reset, `word_q` is zero, `sdo` and `upd_p` are low, and the edge counter is cleared. The counter restarts at each falling frame strobe edge and saturates at 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Chain output carrying bits beyond the 16th |
| word_q | output | WORD_W | Holding register with the last committed word |
| upd_p | output | 1 | One-cycle strobe marking a commit |

## Verification
The bench builds the block with its default word width of 16. That width lets each frame-length boundary be driven exactly: one edge, ten edges, fifteen edges (discarded), sixteen edges (committed), and seventeen or more edges (the chain output becomes active). Frames of 24 and 40 bits check that the chain output repeats the frame's opening bits with a 16-edge delay, and that the committed word is the frame's last 16 bits.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] word_q,
  output logic              upd_p
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic [2:0]        frm_p, sclk_p;
  logic [1:0]        sdi_p;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  wire frm_fall  = frm_p[2] & ~frm_p[1];
  wire frm_rise  = ~frm_p[2] & frm_p[1];
  wire shift_en  = sclk_p[2] & ~sclk_p[1] & ~frm_p[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_p  <= '1;
      sclk_p <= '1;
      sdi_p  <= '0;
    end else begin
      frm_p  <= {frm_p[1:0], frm_n};
      sclk_p <= {sclk_p[1:0], sclk};
      sdi_p  <= {sdi_p[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      sdo    <= 1'b0;
      word_q <= '0;
      upd_p  <= 1'b0;
    end else begin
      upd_p <= 1'b0;
      if (frm_fall) begin
        cnt <= '0;
        sdo <= 1'b0;
      end else if (shift_en) begin
        shreg <= {shreg[WORD_W-2:0], sdi_p[1]};
        if (cnt >= FULL) sdo <= shreg[WORD_W-1];
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end else if (frm_rise) begin
        sdo <= 1'b0;
        if (cnt >= FULL) begin
          word_q <= shreg;
          upd_p  <= 1'b1;
        end
      end
    end
  end
endmodule

module serial_frame_rx_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              upd_p,
  input logic [WORD_W-1:0] word_q,
  input logic [CNT_W-1:0]  cnt
);
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_p |=> !upd_p); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_p |-> $stable(word_q)); // R3
  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    upd_p |-> cnt >= CNT_W'(WORD_W)); // R4
  AST_SDO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    sdo |-> cnt == CNT_W'(WORD_W + 1)); // R5
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W + 1)); // R7
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .upd_p(upd_p), .word_q(word_q), .cnt(cnt)
);

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, frm_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdo, upd_p;
  logic [15:0] word_q;
  logic [15:0] exp_q[$];
  logic [15:0] last_word = '0;
  int checks = 0, fails = 0, n_upd = 0, n_exp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_frame_rx #(.WORD_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .word_q(word_q), .upd_p(upd_p)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic [63:0] pat);
    frm_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      sdi  = pat[n-1-i];
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
      if (i >= 16) check("R5 chain bit", {15'd0, sdo}, {15'd0, pat[n-1-(i-16)]});
      else         check("R5 quiet", {15'd0, sdo}, 16'd0);
    end
    sclk = 1'b1;
    wait_clk(HALF);
    if (n >= 16) begin
      exp_q.push_back(pat[15:0]);
      last_word = pat[15:0];
      n_exp++;
    end
    frm_n = 1'b1;
    wait_clk(3 * HALF);
    check("R5 low after close", {15'd0, sdo}, 16'd0);
    check("R3/R4 hold", word_q, last_word);
  endtask

  initial begin : monitor
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (upd_p) begin
        n_upd++;
        if (prev) check("R6 pulse width", 16'd1, 16'd0);
        if (exp_q.size() == 0) check("R4 unexpected commit", word_q, 16'hxxxx);
        else check("R2 committed word", word_q, exp_q.pop_front());
      end
      prev = upd_p;
    end
  end

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    check("R7 word reset", word_q, 16'd0);
    check("R7 sdo reset", {15'd0, sdo}, 16'd0);
    check("R7 upd reset", {15'd0, upd_p}, 16'd0);
    rst_n = 1'b1;
    wait_clk(4);
    // R1: clock toggles with frame high shift nothing
    for (int i = 0; i < 20; i++) begin
      sdi = 1'b1; sclk = 1'b0; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF);
    end
    check("R1 idle clocks", word_q, 16'd0);
    run_frame(16, 64'hA5C3);
    run_frame(16, 64'hFFFF);
    run_frame(15, 64'h1234);      // R4 one short
    run_frame(10, 64'h3FF);       // R4
    run_frame(1, 64'h1);          // R4
    run_frame(16, 64'h0001);      // R1/R2 lsb placement
    run_frame(17, 64'h1_8000);    // R5 first chain bit
    run_frame(24, 64'hC3_5A96);   // R2/R5
    run_frame(40, 64'hF0_1234_ABCD); // R2/R5 long chain
    run_frame(16, 64'h8000);
    wait_clk(10);
    check("R6 commit count", 16'(n_upd), 16'(n_exp));
    check("R6 queue drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule